// File: doc/BRIEF.md
# Command Decoder and Display Data Router for a Segment Display Driver

This block sits behind the serial slave front end of a segment display driver. Once the front end has matched the bus address, it passes each received byte to this block. The block sorts the bytes of one transfer into two phases.

The transfer opens in the command phase. In that phase the top bit of every byte is a continuation flag. A set flag keeps the next byte in the command phase. A clear flag moves every later byte of the transfer into the data phase. Command bytes update five groups of configuration state:
- drive mode
- RAM write pointer
- device subaddress counter
- bank choice
- blink setting

Display bytes go to a RAM write port at the current pointer. After each display byte the pointer steps forward, and the subaddress counter steps when the pointer wraps. This lets a stream of display bytes run across several cascaded devices.

For every byte the block tells the front end whether to acknowledge it. Every device acknowledges command bytes. A display byte is acknowledged only by the device whose 3-bit strap equals the subaddress counter.

Top module: `lcd_cmd_router`

## Requirements
- R1: After reset, all configuration outputs, the pointer, the subaddress and `data_phase_o` are 0, and `wr_en_o` is 0.
- R2: In the command phase, a byte with bit 7 = 1 keeps the block in the command phase. A byte with bit 7 = 0 sets `data_phase_o` from the next cycle until the next start. No command byte causes a RAM write.
- R3: Command bits[6:5] = 10 selects mode. The fields are `mode_lp_o` = bit 4, `mode_en_o` = bit 3, `mode_bias_o` = bit 2 and `mode_mux_o` = bits[1:0].
- R4: Command bit 6 = 0 loads `ptr_o` from bits[5:0].
- R5: Command bits[6:3] = 1100 loads `sub_o` from bits[2:0].
- R6: Command bits[6:2] = 11110 sets `bank_in_o` = bit 1 and `bank_out_o` = bit 0.
- R7: Command bits[6:3] = 1110 sets `blink_alt_o` = bit 2 and `blink_freq_o` = bits[1:0].
- R8: Command patterns bits[6:3] = 1101 and bits[6:2] = 11111 change no configuration state. Their bit 7 still decides the phase.
- R9: In the command phase, `ack_o` is 1 for every valid byte, whatever the strap.
- R10: A display byte that arrives while `sub_o` equals `strap_i` is acknowledged in the same cycle. In the next cycle `wr_en_o` = 1, `wr_addr_o` holds the pointer value from before the byte, and `wr_data_o` holds the byte.
- R11: A display byte that arrives while `sub_o` differs from `strap_i` gets `ack_o` = 0 and no write. The pointer still advances.
- R12: After each display byte the pointer increments. A byte stored at pointer `PTR_LAST` (39) or above returns the pointer to 0 and increments `sub_o` modulo 8.
- R13: `start_i` returns the block to the command phase. A byte presented in the same cycle is treated as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start of a new addressed transfer |
| byte_valid_i | input | 1 | A received byte is present this cycle |
| byte_i | input | 8 | Received byte |
| strap_i | input | 3 | Hardware subaddress strap of this device |
| ack_o | output | 1 | Acknowledge the present byte (combinational) |
| data_phase_o | output | 1 | Later bytes are display data |
| wr_en_o | output | 1 | RAM write strobe |
| wr_addr_o | output | 6 | RAM write address |
| wr_data_o | output | 8 | RAM write data |
| ptr_o | output | 6 | Current data pointer |
| sub_o | output | 3 | Current subaddress counter |
| mode_lp_o | output | 1 | Low-power mode |
| mode_en_o | output | 1 | Display enable |
| mode_bias_o | output | 1 | Bias select |
| mode_mux_o | output | 2 | Multiplex select |
| bank_in_o | output | 1 | Input bank select |
| bank_out_o | output | 1 | Output bank select |
| blink_alt_o | output | 1 | Alternate-bank blink |
| blink_freq_o | output | 2 | Blink frequency |

## Verification
A wrong phase flag shows up within one byte. `ack_o` goes low on a command byte, or a display byte is decoded as a command and disturbs the configuration outputs in the next cycle.

A pointer or subaddress that drifts, or fails to wrap, shows one cycle after the display byte in `ptr_o` and `sub_o`. It also shows in a wrong `wr_addr_o`, or in a missing or extra `wr_en_o` pulse on the following stored bytes.

Decode errors show one cycle after the command byte, as a changed field in the wrong group or as a change caused by an unused pattern.

// File: rtl/lcdcr_pkg.sv
package lcdcr_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_MODE,
        CMD_PTR,
        CMD_DEV,
        CMD_BANK,
        CMD_BLINK
    } cmd_kind_e;

    typedef struct packed {
        logic       lp;
        logic       en;
        logic       bias;
        logic [1:0] mux;
    } mode_cfg_t;

    typedef struct packed {
        logic bank_in;
        logic bank_out;
    } bank_cfg_t;

    typedef struct packed {
        logic       alt;
        logic [1:0] freq;
    } blink_cfg_t;

    typedef struct packed {
        cmd_kind_e  kind;
        logic       more;
        logic [6:0] arg;
    } cmd_dec_t;

endpackage

// File: rtl/lcdcr_cmd_decode.sv
module lcdcr_cmd_decode
    import lcdcr_pkg::*;
(
    input  logic [7:0] cmd_byte_i,
    output cmd_dec_t   dec_o
);

    always_comb begin
        dec_o.more = cmd_byte_i[7];
        dec_o.arg  = cmd_byte_i[6:0];
        casez (cmd_byte_i[6:2])
            5'b0????: dec_o.kind = CMD_PTR;
            5'b10???: dec_o.kind = CMD_MODE;
            5'b1100?: dec_o.kind = CMD_DEV;
            5'b1110?: dec_o.kind = CMD_BLINK;
            5'b11110: dec_o.kind = CMD_BANK;
            default:  dec_o.kind = CMD_NONE;
        endcase
    end

endmodule

// File: rtl/lcdcr_addr_step.sv
module lcdcr_addr_step #(
    parameter int PTR_W    = 6,
    parameter int SUB_W    = 3,
    parameter int PTR_LAST = 39
) (
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [SUB_W-1:0] sub_i,
    output logic [PTR_W-1:0] ptr_nx_o,
    output logic [SUB_W-1:0] sub_nx_o
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(PTR_LAST);

    always_comb begin
        if (ptr_i >= LAST_PTR) begin
            ptr_nx_o = '0;
            sub_nx_o = sub_i + 1'b1;
        end else begin
            ptr_nx_o = ptr_i + 1'b1;
            sub_nx_o = sub_i;
        end
    end

endmodule

// File: rtl/lcd_cmd_router.sv
module lcd_cmd_router
    import lcdcr_pkg::*;
#(
    parameter int PTR_W    = 6,
    parameter int SUB_W    = 3,
    parameter int PTR_LAST = 39
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_i,
    input  logic [SUB_W-1:0] strap_i,
    output logic             ack_o,
    output logic             data_phase_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_addr_o,
    output logic [7:0]       wr_data_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic [SUB_W-1:0] sub_o,
    output logic             mode_lp_o,
    output logic             mode_en_o,
    output logic             mode_bias_o,
    output logic [1:0]       mode_mux_o,
    output logic             bank_in_o,
    output logic             bank_out_o,
    output logic             blink_alt_o,
    output logic [1:0]       blink_freq_o
);

    localparam int PTR_FIELD_W = 6;
    localparam int SUB_FIELD_W = 3;

    typedef struct packed {
        logic             data_ph;
        logic [PTR_W-1:0] ptr;
        logic [SUB_W-1:0] sub;
        mode_cfg_t        mode;
        bank_cfg_t        bank;
        blink_cfg_t       blink;
        logic             wr_en;
        logic [PTR_W-1:0] wr_addr;
        logic [7:0]       wr_data;
    } state_t;

    state_t           st_d, st_q;
    cmd_dec_t         dec;
    logic [PTR_W-1:0] ptr_nx;
    logic [SUB_W-1:0] sub_nx;
    logic             cmd_ph;
    logic             sub_match;

    lcdcr_cmd_decode i_dec (
        .cmd_byte_i (byte_i),
        .dec_o      (dec)
    );

    lcdcr_addr_step #(
        .PTR_W    (PTR_W),
        .SUB_W    (SUB_W),
        .PTR_LAST (PTR_LAST)
    ) i_step (
        .ptr_i    (st_q.ptr),
        .sub_i    (st_q.sub),
        .ptr_nx_o (ptr_nx),
        .sub_nx_o (sub_nx)
    );

    assign cmd_ph    = start_i | ~st_q.data_ph;
    assign sub_match = (st_q.sub == strap_i);

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        if (start_i) begin
            st_d.data_ph = 1'b0;
        end
        if (byte_valid_i) begin
            if (cmd_ph) begin
                st_d.data_ph = ~dec.more;
                case (dec.kind)
                    CMD_MODE: begin
                        st_d.mode.lp   = dec.arg[4];
                        st_d.mode.en   = dec.arg[3];
                        st_d.mode.bias = dec.arg[2];
                        st_d.mode.mux  = dec.arg[1:0];
                    end
                    CMD_PTR: begin
                        st_d.ptr = PTR_W'(dec.arg[PTR_FIELD_W-1:0]);
                    end
                    CMD_DEV: begin
                        st_d.sub = SUB_W'(dec.arg[SUB_FIELD_W-1:0]);
                    end
                    CMD_BANK: begin
                        st_d.bank.bank_in  = dec.arg[1];
                        st_d.bank.bank_out = dec.arg[0];
                    end
                    CMD_BLINK: begin
                        st_d.blink.alt  = dec.arg[2];
                        st_d.blink.freq = dec.arg[1:0];
                    end
                    default: begin
                    end
                endcase
            end else begin
                st_d.wr_en   = sub_match;
                st_d.wr_addr = st_q.ptr;
                st_d.wr_data = byte_i;
                st_d.ptr     = ptr_nx;
                st_d.sub     = sub_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o        = byte_valid_i & (cmd_ph | sub_match);
    assign data_phase_o = st_q.data_ph;
    assign wr_en_o      = st_q.wr_en;
    assign wr_addr_o    = st_q.wr_addr;
    assign wr_data_o    = st_q.wr_data;
    assign ptr_o        = st_q.ptr;
    assign sub_o        = st_q.sub;
    assign mode_lp_o    = st_q.mode.lp;
    assign mode_en_o    = st_q.mode.en;
    assign mode_bias_o  = st_q.mode.bias;
    assign mode_mux_o   = st_q.mode.mux;
    assign bank_in_o    = st_q.bank.bank_in;
    assign bank_out_o   = st_q.bank.bank_out;
    assign blink_alt_o  = st_q.blink.alt;
    assign blink_freq_o = st_q.blink.freq;

endmodule

// File: rtl/lcdcr_checker.sv
module lcdcr_checker #(
    parameter int PTR_W    = 6,
    parameter int SUB_W    = 3,
    parameter int PTR_LAST = 39
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             byte_valid_i,
    input logic             ack_o,
    input logic             data_phase_o,
    input logic             wr_en_o,
    input logic [PTR_W-1:0] ptr_o,
    input logic [SUB_W-1:0] sub_o
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(PTR_LAST);

    logic data_byte;
    assign data_byte = byte_valid_i & data_phase_o & ~start_i;

    // R9: every byte in the command phase is acknowledged
    assert_cmd_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_i && !data_phase_o) |-> ack_o);

    // R2: a command byte never produces a write
    assert_no_cmd_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_i && !data_phase_o) |=> !wr_en_o);

    // R10: a write only follows an acknowledged display byte
    assert_write_acked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid_i || !data_phase_o || start_i || !ack_o) |=> !wr_en_o);

    // R12: pointer steps by one or wraps to zero after a display byte
    assert_ptr_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (data_byte && ptr_o < LAST_PTR) |=> (ptr_o == $past(ptr_o) + 1'b1) && $stable(sub_o));

    // R12: wrap moves the subaddress on
    assert_ptr_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (data_byte && ptr_o >= LAST_PTR) |=> (ptr_o == '0) && (sub_o == $past(sub_o) + 1'b1));

    // R13: a start without a byte leaves the command phase active
    assert_start_cmd_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !byte_valid_i) |=> !data_phase_o);

    // R11: idle cycles leave pointer and subaddress untouched
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid_i |=> $stable(ptr_o) && $stable(sub_o));

endmodule

bind lcd_cmd_router lcdcr_checker #(
    .PTR_W    (PTR_W),
    .SUB_W    (SUB_W),
    .PTR_LAST (PTR_LAST)
) i_lcdcr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .byte_valid_i (byte_valid_i),
    .ack_o        (ack_o),
    .data_phase_o (data_phase_o),
    .wr_en_o      (wr_en_o),
    .ptr_o        (ptr_o),
    .sub_o        (sub_o)
);

// File: tb/test_lcd_cmd_router.sv
`timescale 1ns/1ps
module test_lcd_cmd_router;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic [2:0] strap_i = 3'd3;
    logic       ack_o, data_phase_o, wr_en_o;
    logic [5:0] wr_addr_o, ptr_o;
    logic [7:0] wr_data_o;
    logic [2:0] sub_o;
    logic       mode_lp_o, mode_en_o, mode_bias_o, bank_in_o, bank_out_o, blink_alt_o;
    logic [1:0] mode_mux_o, blink_freq_o;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;
    logic last_ack, last_wr;

    always #10 clk = ~clk;

    lcd_cmd_router i_lcd_cmd_router (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .byte_valid_i (byte_valid_i), .byte_i (byte_i), .strap_i (strap_i),
        .ack_o (ack_o), .data_phase_o (data_phase_o), .wr_en_o (wr_en_o),
        .wr_addr_o (wr_addr_o), .wr_data_o (wr_data_o), .ptr_o (ptr_o),
        .sub_o (sub_o), .mode_lp_o (mode_lp_o), .mode_en_o (mode_en_o),
        .mode_bias_o (mode_bias_o), .mode_mux_o (mode_mux_o),
        .bank_in_o (bank_in_o), .bank_out_o (bank_out_o),
        .blink_alt_o (blink_alt_o), .blink_freq_o (blink_freq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_valid_i = 1'b1;
        byte_i = b;
        #5 last_ack = ack_o;
        @(negedge clk);
        byte_valid_i = 1'b0;
        last_wr = wr_en_o;
    endtask

    task automatic do_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ptr", ptr_o, 0);
        chk("R1 sub", sub_o, 0);
        chk("R1 phase", data_phase_o, 0);
        chk("R1 wr_en", wr_en_o, 0);
        chk("R1 cfg", {mode_lp_o, mode_en_o, mode_bias_o, mode_mux_o,
                       bank_in_o, bank_out_o, blink_alt_o, blink_freq_o}, 0);
    endtask

    task automatic t_config();
        do_start();
        send_byte(8'hDB);
        chk("R9 ack mode", last_ack, 1);
        chk("R3 lp", mode_lp_o, 1);
        chk("R3 en", mode_en_o, 1);
        chk("R3 bias", mode_bias_o, 0);
        chk("R3 mux", mode_mux_o, 3);
        chk("R2 stay cmd", data_phase_o, 0);
        send_byte(8'hF6);
        chk("R7 alt", blink_alt_o, 1);
        chk("R7 freq", blink_freq_o, 2);
        chk("R2 no write", last_wr, 0);
        send_byte(8'hFA);
        chk("R6 in", bank_in_o, 1);
        chk("R6 out", bank_out_o, 0);
        chk("R3 mode kept", mode_mux_o, 3);
    endtask

    task automatic t_unused();
        send_byte(8'hE9);
        send_byte(8'hFC);
        chk("R8 mode", {mode_lp_o, mode_en_o, mode_bias_o, mode_mux_o}, 5'b11011);
        chk("R8 bank", {bank_in_o, bank_out_o}, 2);
        chk("R8 blink", {blink_alt_o, blink_freq_o}, 3'b110);
        chk("R8 ptr sub", {ptr_o, sub_o}, 0);
        chk("R8 still cmd", data_phase_o, 0);
        send_byte(8'h69);
        chk("R8 C obeyed", data_phase_o, 1);
        chk("R8 ptr kept", ptr_o, 0);
    endtask

    task automatic t_store_match();
        strap_i = 3'd3;
        do_start();
        chk("R13 cmd again", data_phase_o, 0);
        send_byte(8'hE3);
        chk("R5 sub", sub_o, 3);
        send_byte(8'h05);
        chk("R4 ptr", ptr_o, 5);
        chk("R2 to data", data_phase_o, 1);
        send_byte(8'hA5);
        chk("R10 ack", last_ack, 1);
        chk("R10 wr_en", last_wr, 1);
        chk("R10 addr", wr_addr_o, 5);
        chk("R10 data", wr_data_o, 8'hA5);
        chk("R12 ptr inc", ptr_o, 6);
        send_byte(8'h3C);
        chk("R10 addr2", wr_addr_o, 6);
        chk("R10 data2", wr_data_o, 8'h3C);
        chk("R2 stays data", data_phase_o, 1);
    endtask

    task automatic t_store_miss();
        do_start();
        send_byte(8'hE2);
        send_byte(8'h0A);
        send_byte(8'h11);
        chk("R11 ack", last_ack, 0);
        chk("R11 no wr", last_wr, 0);
        chk("R11 ptr adv", ptr_o, 11);
        chk("R11 sub kept", sub_o, 2);
    endtask

    task automatic t_wrap();
        do_start();
        send_byte(8'hE2);
        send_byte(8'h27);
        send_byte(8'h55);
        chk("R12 wrap ptr", ptr_o, 0);
        chk("R12 wrap sub", sub_o, 3);
        send_byte(8'h77);
        chk("R12 now match ack", last_ack, 1);
        chk("R12 now match addr", wr_addr_o, 0);
        chk("R12 now match wr", last_wr, 1);
        do_start();
        send_byte(8'hE7);
        send_byte(8'h3F);
        send_byte(8'h00);
        chk("R12 sub modulo", sub_o, 0);
        chk("R12 over-last ptr", ptr_o, 0);
    endtask

    task automatic t_start_mid();
        chk("R13 pre data", data_phase_o, 1);
        strap_i = 3'd5;
        @(negedge clk);
        start_i = 1'b1;
        byte_valid_i = 1'b1;
        byte_i = 8'hC0;
        #5 last_ack = ack_o;
        @(negedge clk);
        start_i = 1'b0;
        byte_valid_i = 1'b0;
        chk("R13 ack as cmd", last_ack, 1);
        chk("R13 no write", wr_en_o, 0);
        chk("R13 mode cleared", {mode_lp_o, mode_en_o, mode_bias_o, mode_mux_o}, 0);
        chk("R13 cmd phase", data_phase_o, 0);
        send_byte(8'h80);
        chk("R9 ack mismatched", last_ack, 1);
        chk("R4 ptr zero", ptr_o, 0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_unused();
        t_store_match();
        t_store_miss();
        t_wrap();
        t_start_mid();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule